// File: doc/BRIEF.md
# Sample-Playback Voice Sequencer

This block is one voice of a sample-playback sound unit. It takes 16-bit data words, either fetched on its own one-word DMA requests or written directly by a processor. It plays each word as two 8-bit samples, upper byte first. A period counter sets how many sample ticks each byte is held. A length counter counts the words of a block and arms an interrupt when the block wraps.

Control is a fixed five-state automaton. From idle, the voice either plays a processor-written word straight away, or enters a DMA start-up path. That path discards the first ("dummy") word, keeps the second, and then alternates between the upper-byte and lower-byte playback states. Period, length and volume are held in backup latches. Each counter is reloaded from its latch at the transitions that call for it.

Top module: `audio_voice_fsm`

## Requirements
- R1: The state is visible on `stateOut` with the encoding idle=000, prime-wait=001, fetch-wait=101, emit-high=010, emit-low=011. After reset the voice is idle, with `sampleOut`, `volOut`, `dmaReq` and `irqReq` all zero.
- R2: In idle, with `dmaOn` low, `irqPend` low and an unconsumed data word present, the voice moves to emit-high. It loads the word into the output buffer, reloads period and volume, and pulses `irqReq` in the cycle emit-high first shows.
- R3: In idle with `dmaOn` high, the voice moves to prime-wait on the next edge, reloads length and period, and pulses `dmaReq` in that cycle.
- R4: In prime-wait or fetch-wait, a low `dmaOn` returns the voice to idle on the next edge.
- R5: In prime-wait, with `dmaOn` high and a data word present, the voice discards the word, moves to fetch-wait and pulses `irqReq`. The length counter decrements unless it equals 1.
- R6: In fetch-wait, with `dmaOn` high and a data word present, the voice loads the word into the output buffer, reloads period and volume, moves to emit-high and pulses `dmaReq`.
- R7: In the emit states the period counter decrements on each `tickEn` cycle. It is finished at value 1, so each byte is held for exactly the period latch value in ticks.
- R8: `sampleOut` shows the buffer's bits 15:8 in emit-high and bits 7:0 in emit-low, and zero in every other state.
- R9: When emit-low's period finishes with `dmaOn` high and `irqPend` low, the voice reloads the buffer from the holding latch, reloads the period, pulses `dmaReq` and moves to emit-high. On any other finish it goes to idle.
- R10: At an emit-high to emit-low or emit-low to emit-high transition with `dmaOn` high and a newly arrived word, the length counter is handled. If it equals 1, it is reloaded and a deferred interrupt is armed; otherwise it decrements. An armed interrupt pulses `irqReq` at the next emit-low to emit-high transition.
- R11: A volume write with bit 6 set stores 64; otherwise it stores bits 5:0. The stored value reaches `volOut` at the next volume reload.
- R12: `dmaReq` and `irqReq` are single-cycle pulses, never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Sample tick enable for the period counter |
| perWr | input | 1 | Period latch write strobe |
| perData | input | 16 | Period value |
| lenWr | input | 1 | Length latch write strobe |
| lenData | input | 16 | Length value in words |
| volWr | input | 1 | Volume latch write strobe |
| volIn | input | 7 | Volume code (bit 6 forces 64) |
| datWr | input | 1 | Data word strobe (DMA or processor) |
| datIn | input | 16 | Data word |
| dmaOn | input | 1 | DMA enable for this voice |
| irqPend | input | 1 | Interrupt already pending for this voice |
| dmaReq | output | 1 | One-word DMA request pulse |
| irqReq | output | 1 | Interrupt request pulse |
| sampleOut | output | 8 | Current 8-bit sample |
| volOut | output | 7 | Current volume |
| stateOut | output | 3 | Automaton state code |

## Verification
A strobe on `datWr`, `perWr`, `lenWr` or `volWr` lands in its latch or flag at the first edge. A state transition that depends on it takes effect at the second edge. `stateOut`, `sampleOut`, `dmaReq`, `irqReq` and `volOut` all change at that transition edge, because the request pulses are registered together with the state. The bench drives inputs on the falling edge and samples every output at the next falling edge. A cycle-stepped expectation model, written from the requirements, advances on each rising edge and is compared with every output at each falling edge. Directed sequences then count edges by hand for the processor path, the period hold time, the DMA start-up and the volume coding.

// File: rtl/audio_voice_pkg.sv
package audio_voice_pkg;

  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;
  localparam int VOL_W  = 7;

  typedef enum logic [2:0] {
    VS_IDLE      = 3'b000,
    VS_PRIME     = 3'b001,
    VS_FETCH     = 3'b101,
    VS_EMIT_HI   = 3'b010,
    VS_EMIT_LO   = 3'b011
  } voiceState_e;

  // Strobes from the control automaton to the datapath
  typedef struct packed {
    logic bufLoad;
    logic perLoad;
    logic perDec;
    logic lenLoad;
    logic lenDec;
    logic volLoad;
  } voiceCtl_t;

endpackage

// File: rtl/audio_voice_ctrl.sv
module audio_voice_ctrl
  import audio_voice_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        datWr,
  input  logic        dmaOn,
  input  logic        irqPend,
  input  logic        perFin,
  input  logic        lenFin,
  output voiceCtl_t   ctl,
  output voiceState_e state,
  output logic        dmaReq,
  output logic        irqReq
);

  voiceState_e nextState;
  logic hasData, newWord, armed;
  logic dmaSet, irqSet, hasClr, newClr, armSet, armFire, lenStep;

  always_comb begin
    nextState = state;
    ctl       = '0;
    dmaSet    = 1'b0;
    irqSet    = 1'b0;
    hasClr    = 1'b0;
    newClr    = 1'b0;
    armSet    = 1'b0;
    armFire   = 1'b0;
    lenStep   = 1'b0;
    unique case (state)
      VS_IDLE: begin
        if (dmaOn) begin
          nextState   = VS_PRIME;
          ctl.lenLoad = 1'b1;
          ctl.perLoad = 1'b1;
          dmaSet      = 1'b1;
        end else if (!irqPend && hasData) begin
          nextState   = VS_EMIT_HI;
          ctl.bufLoad = 1'b1;
          ctl.perLoad = 1'b1;
          ctl.volLoad = 1'b1;
          irqSet      = 1'b1;
          hasClr      = 1'b1;
          newClr      = 1'b1;
        end
      end
      VS_PRIME: begin
        if (!dmaOn) begin
          nextState = VS_IDLE;
        end else if (hasData) begin
          nextState  = VS_FETCH;
          irqSet     = 1'b1;
          ctl.lenDec = !lenFin;
          hasClr     = 1'b1;
          newClr     = 1'b1;
        end
      end
      VS_FETCH: begin
        if (!dmaOn) begin
          nextState = VS_IDLE;
        end else if (hasData) begin
          nextState   = VS_EMIT_HI;
          ctl.bufLoad = 1'b1;
          ctl.perLoad = 1'b1;
          ctl.volLoad = 1'b1;
          dmaSet      = 1'b1;
          hasClr      = 1'b1;
          newClr      = 1'b1;
        end
      end
      VS_EMIT_HI: begin
        if (tickEn) begin
          if (perFin) begin
            nextState   = VS_EMIT_LO;
            ctl.perLoad = 1'b1;
            lenStep     = dmaOn && newWord;
          end else begin
            ctl.perDec = 1'b1;
          end
        end
      end
      VS_EMIT_LO: begin
        if (tickEn) begin
          if (perFin) begin
            if (dmaOn && !irqPend) begin
              nextState   = VS_EMIT_HI;
              ctl.bufLoad = 1'b1;
              ctl.perLoad = 1'b1;
              dmaSet      = 1'b1;
              hasClr      = 1'b1;
              lenStep     = newWord;
              armFire     = armed;
            end else begin
              nextState = VS_IDLE;
            end
          end else begin
            ctl.perDec = 1'b1;
          end
        end
      end
      default: nextState = VS_IDLE;
    endcase

    if (lenStep) begin
      newClr = 1'b1;
      if (lenFin) begin
        ctl.lenLoad = 1'b1;
        armSet      = 1'b1;
      end else begin
        ctl.lenDec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= VS_IDLE;
      hasData <= 1'b0;
      newWord <= 1'b0;
      armed   <= 1'b0;
      dmaReq  <= 1'b0;
      irqReq  <= 1'b0;
    end else begin
      state   <= nextState;
      dmaReq  <= dmaSet;
      irqReq  <= irqSet | armFire;
      if (datWr)       hasData <= 1'b1;
      else if (hasClr) hasData <= 1'b0;
      if (datWr)       newWord <= 1'b1;
      else if (newClr) newWord <= 1'b0;
      if (armSet)       armed <= 1'b1;
      else if (armFire) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/audio_voice_dp.sv
module audio_voice_dp
  import audio_voice_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W,
  parameter int VW = VOL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  voiceCtl_t     ctl,
  input  voiceState_e   state,
  input  logic          perWr,
  input  logic [CW-1:0] perData,
  input  logic          lenWr,
  input  logic [CW-1:0] lenData,
  input  logic          volWr,
  input  logic [VW-1:0] volIn,
  input  logic          datWr,
  input  logic [DW-1:0] datIn,
  output logic          perFin,
  output logic          lenFin,
  output logic [DW/2-1:0] sampleOut,
  output logic [VW-1:0] volOut
);

  localparam int HALF_W = DW / 2;
  localparam logic [VW-1:0] VOL_FULL = VW'(1) << (VW - 1);

  logic [CW-1:0] perLat, lenLat, perCnt, lenCnt;
  logic [VW-1:0] volLat;
  logic [DW-1:0] holdLat, outBuf;
  logic [VW-1:0] volDecoded;

  // Top code bit forces full scale; otherwise the lower bits are the level
  assign volDecoded = volIn[VW-1] ? VOL_FULL : {1'b0, volIn[VW-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perLat  <= '0;
      lenLat  <= '0;
      volLat  <= '0;
      holdLat <= '0;
    end else begin
      if (perWr) perLat  <= perData;
      if (lenWr) lenLat  <= lenData;
      if (volWr) volLat  <= volDecoded;
      if (datWr) holdLat <= datIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt <= '0;
      lenCnt <= '0;
      outBuf <= '0;
      volOut <= '0;
    end else begin
      if (ctl.perLoad)     perCnt <= perLat;
      else if (ctl.perDec) perCnt <= perCnt - 1'b1;
      if (ctl.lenLoad)     lenCnt <= lenLat;
      else if (ctl.lenDec) lenCnt <= lenCnt - 1'b1;
      if (ctl.bufLoad)     outBuf <= holdLat;
      if (ctl.volLoad)     volOut <= volLat;
    end
  end

  assign perFin = (perCnt == CW'(1));
  assign lenFin = (lenCnt == CW'(1));

  always_comb begin
    unique case (state)
      VS_EMIT_HI: sampleOut = outBuf[DW-1:HALF_W];
      VS_EMIT_LO: sampleOut = outBuf[HALF_W-1:0];
      default:    sampleOut = '0;
    endcase
  end

endmodule

// File: rtl/audio_voice_fsm.sv
module audio_voice_fsm
  import audio_voice_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              perWr,
  input  logic [CNT_W-1:0]  perData,
  input  logic              lenWr,
  input  logic [CNT_W-1:0]  lenData,
  input  logic              volWr,
  input  logic [VOL_W-1:0]  volIn,
  input  logic              datWr,
  input  logic [DATA_W-1:0] datIn,
  input  logic              dmaOn,
  input  logic              irqPend,
  output logic              dmaReq,
  output logic              irqReq,
  output logic [DATA_W/2-1:0] sampleOut,
  output logic [VOL_W-1:0]  volOut,
  output logic [2:0]        stateOut
);

  voiceCtl_t   ctl;
  voiceState_e state;
  logic        perFin, lenFin;

  audio_voice_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .datWr   (datWr),
    .dmaOn   (dmaOn),
    .irqPend (irqPend),
    .perFin  (perFin),
    .lenFin  (lenFin),
    .ctl     (ctl),
    .state   (state),
    .dmaReq  (dmaReq),
    .irqReq  (irqReq)
  );

  audio_voice_dp #(
    .DW (DATA_W),
    .CW (CNT_W),
    .VW (VOL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .state     (state),
    .perWr     (perWr),
    .perData   (perData),
    .lenWr     (lenWr),
    .lenData   (lenData),
    .volWr     (volWr),
    .volIn     (volIn),
    .datWr     (datWr),
    .datIn     (datIn),
    .perFin    (perFin),
    .lenFin    (lenFin),
    .sampleOut (sampleOut),
    .volOut    (volOut)
  );

  assign stateOut = state;

endmodule

// File: rtl/audio_voice_chk.sv
module audio_voice_chk
  import audio_voice_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       dmaOn,
  input logic       dmaReq,
  input logic       irqReq,
  input logic [7:0] sampleOut,
  input logic [2:0] stateOut
);

  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateOut inside {VS_IDLE, VS_PRIME, VS_FETCH, VS_EMIT_HI, VS_EMIT_LO});

  // R3
  dma_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == VS_IDLE && dmaOn) |=> (stateOut == VS_PRIME && dmaReq));

  // R4
  wait_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateOut == VS_PRIME || stateOut == VS_FETCH) && !dmaOn) |=> stateOut == VS_IDLE);

  // R8
  silent_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stateOut == VS_EMIT_HI || stateOut == VS_EMIT_LO) |-> sampleOut == 8'h00);

  // R9
  emit_lo_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateOut == VS_EMIT_LO |=> stateOut inside {VS_EMIT_LO, VS_EMIT_HI, VS_IDLE});

  // R12
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |=> !dmaReq);

  // R12
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);

endmodule

bind audio_voice_fsm audio_voice_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dmaOn     (dmaOn),
  .dmaReq    (dmaReq),
  .irqReq    (irqReq),
  .sampleOut (sampleOut),
  .stateOut  (stateOut)
);

// File: tb/audio_voice_fsm_tb_top.sv
module audio_voice_fsm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] S_IDLE = 3'b000, S_PRIME = 3'b001, S_FETCH = 3'b101,
                         S_HI = 3'b010, S_LO = 3'b011;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, tickEn, perWr, lenWr, volWr, datWr, dmaOn, irqPend;
  logic [15:0] perData, lenData, datIn;
  logic [6:0]  volIn;
  logic dmaReq, irqReq;
  logic [7:0] sampleOut;
  logic [6:0] volOut;
  logic [2:0] stateOut;

  audio_voice_fsm dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .perWr(perWr), .perData(perData),
    .lenWr(lenWr), .lenData(lenData), .volWr(volWr), .volIn(volIn),
    .datWr(datWr), .datIn(datIn), .dmaOn(dmaOn), .irqPend(irqPend),
    .dmaReq(dmaReq), .irqReq(irqReq), .sampleOut(sampleOut),
    .volOut(volOut), .stateOut(stateOut)
  );

  int checks = 0;
  int fails = 0;
  int deferredSeen = 0;

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Expectation model, stepped on each rising edge from the requirements
  logic [2:0]  mSt;
  logic        mHas, mNew, mArm, mDma, mIrq;
  logic [15:0] mPer, mLen, mPerCnt, mLenCnt, mLat, mBuf;
  logic [6:0]  mVol, mVolCnt;

  function automatic logic [6:0] volCode(logic [6:0] v);
    return v[6] ? 7'd64 : {1'b0, v[5:0]};
  endfunction

  function automatic logic [7:0] expSample();
    if (mSt == S_HI) return mBuf[15:8];
    if (mSt == S_LO) return mBuf[7:0];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = S_IDLE; mHas = 0; mNew = 0; mArm = 0; mDma = 0; mIrq = 0;
      mPer = 0; mLen = 0; mPerCnt = 0; mLenCnt = 0; mLat = 0; mBuf = 0;
      mVol = 0; mVolCnt = 0;
    end else begin
      logic [2:0] ns;
      bit bl, pl, vl, ll, ld, pd, ds, is, hc, nc, af, ls;
      ns = mSt; bl = 0; pl = 0; vl = 0; ll = 0; ld = 0; pd = 0;
      ds = 0; is = 0; hc = 0; nc = 0; af = 0; ls = 0;
      case (mSt)
        S_IDLE:
          if (dmaOn) begin ns = S_PRIME; ll = 1; pl = 1; ds = 1; end
          else if (!irqPend && mHas) begin
            ns = S_HI; bl = 1; pl = 1; vl = 1; is = 1; hc = 1; nc = 1;
          end
        S_PRIME:
          if (!dmaOn) ns = S_IDLE;
          else if (mHas) begin
            ns = S_FETCH; is = 1; ld = (mLenCnt != 1); hc = 1; nc = 1;
          end
        S_FETCH:
          if (!dmaOn) ns = S_IDLE;
          else if (mHas) begin
            ns = S_HI; bl = 1; pl = 1; vl = 1; ds = 1; hc = 1; nc = 1;
          end
        S_HI:
          if (tickEn) begin
            if (mPerCnt == 1) begin ns = S_LO; pl = 1; ls = dmaOn && mNew; end
            else pd = 1;
          end
        S_LO:
          if (tickEn) begin
            if (mPerCnt == 1) begin
              if (dmaOn && !irqPend) begin
                ns = S_HI; bl = 1; pl = 1; ds = 1; hc = 1; ls = mNew; af = mArm;
              end else ns = S_IDLE;
            end else pd = 1;
          end
        default: ns = S_IDLE;
      endcase
      if (af && ns == S_HI) deferredSeen++;
      mIrq = is | af;
      mDma = ds;
      if (af) mArm = 0;
      if (ls) begin
        nc = 1;
        if (mLenCnt == 1) begin ll = 1; mArm = 1; end else ld = 1;
      end
      if (bl) mBuf = mLat;
      if (pl) mPerCnt = mPer; else if (pd) mPerCnt = mPerCnt - 1;
      if (ll) mLenCnt = mLen; else if (ld) mLenCnt = mLenCnt - 1;
      if (vl) mVolCnt = mVol;
      if (datWr) mHas = 1; else if (hc) mHas = 0;
      if (datWr) mNew = 1; else if (nc) mNew = 0;
      if (datWr) mLat = datIn;
      if (perWr) mPer = perData;
      if (lenWr) mLen = lenData;
      if (volWr) mVol = volCode(volIn);
      mSt = ns;
    end
  end

  // One cycle: wait for the falling edge, compare every output with the model
  task automatic cyc();
    @(negedge clk);
    if (rstN) begin
      check("R1 state", stateOut, mSt);
      check("R8 sample", sampleOut, expSample());
      check("R3 dmaReq", dmaReq, mDma);
      check("R10 irqReq", irqReq, mIrq);
      check("R11 volOut", volOut, mVolCnt);
    end
  endtask

  task automatic clearStrobes();
    perWr = 0; lenWr = 0; volWr = 0; datWr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog R1 got=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int dmaDelay;
    void'($urandom(32'd20211109));
    rstN = 0; tickEn = 1; clearStrobes(); dmaOn = 0; irqPend = 0;
    perData = 0; lenData = 0; datIn = 0; volIn = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset state", stateOut, S_IDLE);
    check("R1 reset sample", sampleOut, 0);
    check("R1 reset dmaReq", dmaReq, 0);
    check("R1 reset volOut", volOut, 0);
    rstN = 1;
    cyc();
    perWr = 1; perData = 16'd3; lenWr = 1; lenData = 16'd2; volWr = 1; volIn = 7'h4A;
    cyc();
    clearStrobes(); datWr = 1; datIn = 16'hA55A;
    cyc();
    clearStrobes();
    cyc();
    // R2 processor path
    check("R2 cpu state", stateOut, S_HI);
    check("R2 cpu irq", irqReq, 1);
    check("R2 cpu sample", sampleOut, 8'hA5);
    check("R11 vol bit6", volOut, 64);
    cyc();
    check("R12 irq single", irqReq, 0);
    cyc();
    check("R7 hold high", stateOut, S_HI);
    cyc();
    check("R7 to low", stateOut, S_LO);
    check("R8 low byte", sampleOut, 8'h5A);
    repeat (3) cyc();
    check("R9 idle exit", stateOut, S_IDLE);
    check("R9 idle sample", sampleOut, 0);
    volWr = 1; volIn = 7'h25;
    cyc();
    clearStrobes(); datWr = 1; datIn = 16'h0102;
    cyc();
    clearStrobes();
    cyc();
    check("R11 vol low bits", volOut, 37);
    repeat (6) cyc();
    check("R9 back idle", stateOut, S_IDLE);
    // DMA start-up
    dmaOn = 1;
    cyc();
    check("R3 prime", stateOut, S_PRIME);
    check("R3 dma pulse", dmaReq, 1);
    cyc();
    check("R12 dma single", dmaReq, 0);
    dmaOn = 0;
    cyc();
    check("R4 abort", stateOut, S_IDLE);
    dmaOn = 1;
    cyc();
    datWr = 1; datIn = 16'hFFFF;
    cyc();
    clearStrobes();
    cyc();
    check("R5 fetch wait", stateOut, S_FETCH);
    check("R5 irq", irqReq, 1);
    datWr = 1; datIn = 16'h1234;
    cyc();
    clearStrobes();
    cyc();
    check("R6 emit", stateOut, S_HI);
    check("R6 dma", dmaReq, 1);
    check("R6 dummy dropped", sampleOut, 8'h12);

    // Random phase with a DMA responder
    dmaDelay = 0;
    for (int i = 0; i < 6000; i++) begin
      logic sawReq;
      cyc();
      sawReq = dmaReq;
      clearStrobes();
      tickEn  = ($urandom % 4) != 0;
      irqPend = ($urandom % 24) == 0;
      if (($urandom % 300) == 0) dmaOn = ~dmaOn;
      if (($urandom % 150) == 0) begin perWr = 1; perData = 16'(1 + $urandom % 4); end
      if (($urandom % 150) == 0) begin lenWr = 1; lenData = 16'(1 + $urandom % 3); end
      if (($urandom % 200) == 0) begin volWr = 1; volIn = 7'($urandom); end
      if (dmaDelay > 0) begin
        dmaDelay--;
        if (dmaDelay == 0) begin datWr = 1; datIn = 16'($urandom); end
      end else if (sawReq) begin
        dmaDelay = 1 + $urandom % 3;
      end else if (($urandom % 60) == 0) begin
        datWr = 1; datIn = 16'($urandom);
      end
    end
    check("R10 deferred irq seen", int'(deferredSeen > 0), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule